// File: doc/BRIEF.md
# Overlay Command Window Register File

This block is the host-facing register window of a memory device. The host reads and writes 16-bit words at byte offsets on an 8-bit address. The window returns a fixed identification area (a four-character ASCII tag, vendor and part codes, program-buffer placement and size). It holds a set of command parameter registers: an opcode, a target address in two halves, a data count in two halves and a data word. A separate control area holds the execute, buffer-clear and suspend strobes and a device status word.

Loading the parameters does nothing by itself. An operation is launched only when the value 0x0001 is written to the execute offset while the device is ready and the opcode is one of the accepted codes. The operation is simulated by a sequencer with three states. IDLE goes to BUSY on launch. BUSY goes back to IDLE after a fixed number of cycles. BUSY goes to SUSPENDED on a suspend request during a program-class or erase operation. SUSPENDED goes back to BUSY on a resume launch, and the sequencer keeps the cycles still owed.

The status word mixes two kinds of bits. State bits (available, ready, program suspended, erase suspended) are read-only. Error flags are sticky and are cleared by the host reading the status word. A small per-block lock map is kept. The block index is taken from the low bits of the upper address half. Lock and unlock commands update the map, and program or erase commands aimed at a locked block abort at once.

Top module: `ocw_regfile`

## Requirements
- R1: After reset, reads return 0x0050, 0x0046, 0x004F and 0x0057 at offsets 0x00, 0x02, 0x04 and 0x06. Offsets 0x20, 0x22, 0x40 and 0x42 return the MFR_ID, DEV_ID, PBUF_OFS and PBUF_WORDS parameters. The status word at 0xCC reads 0x8080, and every command register reads 0.
- R2: Writes to 0x80 (opcode), 0x84 (data), 0x88/0x8A (address low/high) and 0x90/0x92 (count low/high) read back unchanged one cycle after the read. Writes to the identification offsets have no effect.
- R3: Writing 0x0001 to 0xC0 while ready, with an accepted opcode, clears status bit 7 (ready). The bit stays clear for exactly OP_CYCLES cycles. The accepted opcodes are 0x41, 0xE9, 0x20, 0x61, 0x62, 0x65, 0x98, 0x97, 0xC0 and 0xD0.
- R4: An execute write is ignored in three cases: the value is not 0x0001, the opcode is not accepted, or an operation is already running. An ignored write neither starts nor extends an operation.
- R5: Opcode 0x61 marks the block locked and 0x62 unlocks it. A program-class opcode (0x41, 0xE9, 0xC0) or an erase (0x20) aimed at a locked block does not run, keeps ready at 1 and sets status bit 1.
- R6: Writing 0x0001 to 0xC8 during a program-class operation sets status bit 2. During an erase it sets status bit 6. Ready returns to 1 in both cases, and the two bits are never set together.
- R7: Launching opcode 0xD0 while suspended clears the suspend bit and runs only the cycles that were left. 0xD0 launched while idle does nothing.
- R8: Status bits 1, 3, 4 and 5 are sticky. The error mask 0x133A is cleared by a status read, and that read returns the value before the clear. Bits 12 and 9:8 have no source in this block and read 0. Bit 15 (available) always reads 1.
- R9: When vpp_low is high at launch of a program-class or erase opcode, the operation aborts and status bit 3 is set. Other opcodes run normally.
- R10: When op_fail is high in the last cycle of an operation, status bit 4 is set for a program-class operation and bit 5 for an erase.
- R11: Opcode 0x65 loads the lock bit of the addressed block into the data register at 0x84.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; rdata updates on the next edge |
| addr | input | 8 | Byte offset in the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| vpp_low | input | 1 | Low programming voltage indication |
| op_fail | input | 1 | Operation failure indication, sampled at completion |

## Verification
A sequencer stuck in the wrong state shows up at the status word within one read. A lost or restarted countdown moves the cycle in which ready returns, so the bench reads status in the last busy cycle and in the first ready cycle. A wrong lock map shows up as an abort flag, or the lack of one, on the next program or erase. It also shows up in the data register after a lock-status command. A sticky flag that fails to clear, or clears without a read, is caught by two reads in a row.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
    localparam logic [7:0] A_TAG0   = 8'h00;
    localparam logic [7:0] A_TAG1   = 8'h02;
    localparam logic [7:0] A_TAG2   = 8'h04;
    localparam logic [7:0] A_TAG3   = 8'h06;
    localparam logic [7:0] A_MFR    = 8'h20;
    localparam logic [7:0] A_DEV    = 8'h22;
    localparam logic [7:0] A_PBOFS  = 8'h40;
    localparam logic [7:0] A_PBSZ   = 8'h42;
    localparam logic [7:0] A_OPC    = 8'h80;
    localparam logic [7:0] A_DATA   = 8'h84;
    localparam logic [7:0] A_ADRL   = 8'h88;
    localparam logic [7:0] A_ADRH   = 8'h8A;
    localparam logic [7:0] A_CNTL   = 8'h90;
    localparam logic [7:0] A_CNTH   = 8'h92;
    localparam logic [7:0] A_GO     = 8'hC0;
    localparam logic [7:0] A_BCLR   = 8'hC4;
    localparam logic [7:0] A_SUSP   = 8'hC8;
    localparam logic [7:0] A_STAT   = 8'hCC;

    localparam logic [15:0] STROBE_VAL = 16'h0001;
    localparam logic [7:0]  OPC_RESUME = 8'hD0;
    localparam logic [7:0]  OPC_LOCK   = 8'h61;
    localparam logic [7:0]  OPC_UNLOCK = 8'h62;
    localparam logic [7:0]  OPC_LKSTAT = 8'h65;

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_SUSP} op_state_e;
    typedef enum logic [1:0] {K_OTHER, K_PROG, K_ERASE} op_kind_e;

    function automatic logic opc_known(input logic [15:0] c);
        logic ok;
        ok = 1'b0;
        if (c[15:8] == 8'h00) begin
            unique case (c[7:0])
                8'h41, 8'hE9, 8'h20, 8'h61, 8'h62,
                8'h65, 8'h98, 8'h97, 8'hC0, 8'hD0: ok = 1'b1;
                default:                           ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    function automatic op_kind_e opc_kind(input logic [7:0] c);
        op_kind_e k;
        unique case (c)
            8'h41, 8'hE9, 8'hC0: k = K_PROG;
            8'h20:               k = K_ERASE;
            default:             k = K_OTHER;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/ocw_lock_map.sv
module ocw_lock_map #(
    parameter int NBLK = 8,
    localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [IW-1:0] idx,
    output logic          locked
);
    logic [NBLK-1:0] bits;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bits[b] <= 1'b0;
            else if (idx == IW'(b)) begin
                if (set_en)      bits[b] <= 1'b1;
                else if (clr_en) bits[b] <= 1'b0;
            end
        end
    end

    assign locked = bits[idx];
endmodule

// File: rtl/ocw_op_seq.sv
module ocw_op_seq
    import ocw_pkg::*;
#(
    parameter int OP_CYCLES = 8,
    localparam int CW = $clog2(OP_CYCLES + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch,
    input  op_kind_e  kind_in,
    input  logic      suspend_req,
    input  logic      resume_req,
    input  logic      fail_in,
    output op_state_e state,
    output logic [CW-1:0] cnt,
    output logic      ready,
    output logic      psusp,
    output logic      esusp,
    output logic      fail_prog,
    output logic      fail_erase
);
    op_state_e nstate;
    op_kind_e  kind, nkind;
    logic [CW-1:0] ncnt;
    logic susp_ok, last;

    assign susp_ok = suspend_req && (kind != K_OTHER);
    assign last    = (cnt == CW'(1));

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        nkind  = kind;
        unique case (state)
            ST_IDLE: if (launch) begin
                nstate = ST_BUSY;
                ncnt   = CW'(OP_CYCLES);
                nkind  = kind_in;
            end
            ST_BUSY: begin
                if (susp_ok)   nstate = ST_SUSP;
                else if (last) begin
                    nstate = ST_IDLE;
                    ncnt   = '0;
                end
                else           ncnt = cnt - CW'(1);
            end
            ST_SUSP: if (resume_req) nstate = ST_BUSY;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            kind  <= K_OTHER;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
            kind  <= nkind;
        end
    end

    always_comb begin
        ready      = (state != ST_BUSY);
        psusp      = (state == ST_SUSP) && (kind == K_PROG);
        esusp      = (state == ST_SUSP) && (kind == K_ERASE);
        fail_prog  = (state == ST_BUSY) && last && !susp_ok && fail_in && (kind == K_PROG);
        fail_erase = (state == ST_BUSY) && last && !susp_ok && fail_in && (kind == K_ERASE);
    end
endmodule

// File: rtl/ocw_status.sv
module ocw_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_clr,
    input  logic        set_lock,
    input  logic        set_vpp,
    input  logic        set_prog,
    input  logic        set_erase,
    input  logic        ready,
    input  logic        psusp,
    input  logic        esusp,
    output logic [15:0] status
);
    logic f_lock, f_vpp, f_prog, f_erase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_lock  <= 1'b0;
            f_vpp   <= 1'b0;
            f_prog  <= 1'b0;
            f_erase <= 1'b0;
        end else begin
            f_lock  <= (f_lock  && !rd_clr) || set_lock;
            f_vpp   <= (f_vpp   && !rd_clr) || set_vpp;
            f_prog  <= (f_prog  && !rd_clr) || set_prog;
            f_erase <= (f_erase && !rd_clr) || set_erase;
        end
    end

    assign status = {1'b1, 2'b00, 1'b0, 2'b00, 2'b00,
                     ready, esusp, f_erase, f_prog, f_vpp, psusp, f_lock, 1'b0};
endmodule

// File: rtl/ocw_regfile.sv
module ocw_regfile
    import ocw_pkg::*;
#(
    parameter int          OP_CYCLES  = 8,
    parameter int          NBLK       = 8,
    parameter logic [15:0] MFR_ID     = 16'h00A5,
    parameter logic [15:0] DEV_ID     = 16'h5A17,
    parameter logic [15:0] PBUF_OFS   = 16'h0200,
    parameter logic [15:0] PBUF_WORDS = 16'h0020,
    localparam int CW = $clog2(OP_CYCLES + 1),
    localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        vpp_low,
    input  logic        op_fail
);
    logic [15:0] r_opc, r_data, r_adrl, r_adrh, r_cntl, r_cnth;
    logic [15:0] status_w;
    op_state_e   seq_state;
    logic [CW-1:0] seq_cnt;
    logic ready, psusp, esusp, fail_prog, fail_erase;
    logic go_wr, known, blk_locked, guarded;
    logic launch, resume, abort_lock, abort_vpp, err_set;
    op_kind_e kind_now;

    assign go_wr    = wr_en && (addr == A_GO) && (wdata == STROBE_VAL);
    assign known    = opc_known(r_opc);
    assign kind_now = opc_kind(r_opc[7:0]);
    assign guarded  = (kind_now != K_OTHER);

    always_comb begin
        launch     = 1'b0;
        resume     = 1'b0;
        abort_lock = 1'b0;
        abort_vpp  = 1'b0;
        if (go_wr && known) begin
            if (seq_state == ST_IDLE && r_opc[7:0] != OPC_RESUME) begin
                if (guarded && blk_locked)   abort_lock = 1'b1;
                else if (guarded && vpp_low) abort_vpp  = 1'b1;
                else                         launch     = 1'b1;
            end
            if (seq_state == ST_SUSP && r_opc[7:0] == OPC_RESUME)
                resume = 1'b1;
        end
    end

    assign err_set = abort_lock || abort_vpp || fail_prog || fail_erase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_opc  <= '0;
            r_data <= '0;
            r_adrl <= '0;
            r_adrh <= '0;
            r_cntl <= '0;
            r_cnth <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    A_OPC:   r_opc  <= wdata;
                    A_DATA:  r_data <= wdata;
                    A_ADRL:  r_adrl <= wdata;
                    A_ADRH:  r_adrh <= wdata;
                    A_CNTL:  r_cntl <= wdata;
                    A_CNTH:  r_cnth <= wdata;
                    default: ;
                endcase
            end
            if (launch && r_opc[7:0] == OPC_LKSTAT)
                r_data <= {15'd0, blk_locked};
        end
    end

    ocw_lock_map #(.NBLK(NBLK)) lock_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (launch && r_opc[7:0] == OPC_LOCK),
        .clr_en (launch && r_opc[7:0] == OPC_UNLOCK),
        .idx    (r_adrh[IW-1:0]),
        .locked (blk_locked)
    );

    ocw_op_seq #(.OP_CYCLES(OP_CYCLES)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .kind_in     (kind_now),
        .suspend_req (wr_en && addr == A_SUSP && wdata == STROBE_VAL),
        .resume_req  (resume),
        .fail_in     (op_fail),
        .state       (seq_state),
        .cnt         (seq_cnt),
        .ready       (ready),
        .psusp       (psusp),
        .esusp       (esusp),
        .fail_prog   (fail_prog),
        .fail_erase  (fail_erase)
    );

    ocw_status stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_clr    (rd_en && addr == A_STAT),
        .set_lock  (abort_lock),
        .set_vpp   (abort_vpp),
        .set_prog  (fail_prog),
        .set_erase (fail_erase),
        .ready     (ready),
        .psusp     (psusp),
        .esusp     (esusp),
        .status    (status_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            unique case (addr)
                A_TAG0:  rdata <= 16'h0050;
                A_TAG1:  rdata <= 16'h0046;
                A_TAG2:  rdata <= 16'h004F;
                A_TAG3:  rdata <= 16'h0057;
                A_MFR:   rdata <= MFR_ID;
                A_DEV:   rdata <= DEV_ID;
                A_PBOFS: rdata <= PBUF_OFS;
                A_PBSZ:  rdata <= PBUF_WORDS;
                A_OPC:   rdata <= r_opc;
                A_DATA:  rdata <= r_data;
                A_ADRL:  rdata <= r_adrl;
                A_ADRH:  rdata <= r_adrh;
                A_CNTL:  rdata <= r_cntl;
                A_CNTH:  rdata <= r_cnth;
                A_STAT:  rdata <= status_w;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ocw_regfile_chk.sv
module ocw_regfile_chk
    import ocw_pkg::*;
#(
    parameter int OP_CYCLES = 8,
    localparam int CW = $clog2(OP_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [7:0]    addr,
    input logic [15:0]   status,
    input op_state_e     state,
    input logic [CW-1:0] cnt,
    input logic          err_set
);
    // R8
    avail_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) status[15]);

    // R6
    one_susp_chk: assert property (@(posedge clk) disable iff (!rst_n) !(status[2] && status[6]));

    // R6
    susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] || status[6]) |-> status[7]);

    // R8
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT && !err_set) |=> ((status & 16'h133A) == 16'h0000));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(OP_CYCLES));

    // R7
    susp_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP) |=> (state != ST_IDLE));
endmodule

bind ocw_regfile ocw_regfile_chk #(.OP_CYCLES(OP_CYCLES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .status  (status_w),
    .state   (seq_state),
    .cnt     (seq_cnt),
    .err_set (err_set)
);

// File: tb/ocw_regfile_tb_top.sv
module ocw_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    localparam logic [23:0] RST_VEC [NVEC] = '{
        24'h00_0050, 24'h02_0046, 24'h04_004F, 24'h06_0057,
        24'h20_00A5, 24'h22_5A17, 24'h40_0200, 24'h42_0020,
        24'h80_0000, 24'hCC_8080
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, vpp_low = 1'b0, op_fail = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0, rdata, got;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocw_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .vpp_low(vpp_low), .op_fail(op_fail)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic launch(input logic [7:0] opc, input logic [15:0] blk);
        wr(8'h80, {8'h00, opc});
        wr(8'h8A, blk);
        wr(8'hC0, 16'h0001);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            rd(RST_VEC[i][23:16], got);
            chk("R1 reset map", got, RST_VEC[i][15:0]);
        end

        wr(8'h88, 16'h1234); rd(8'h88, got); chk("R2 addr low", got, 16'h1234);
        wr(8'h92, 16'hBEEF); rd(8'h92, got); chk("R2 count high", got, 16'hBEEF);
        wr(8'h20, 16'hFFFF); rd(8'h20, got); chk("R2 id write ignored", got, 16'h00A5);

        // R3: ready low for exactly 8 cycles
        launch(8'h41, 16'h0000);
        repeat (7) @(negedge clk);
        rd(8'hCC, got); chk("R3 last busy cycle", got, 16'h8000);
        rd(8'hCC, got); chk("R3 first ready cycle", got, 16'h8080);

        // R4: bad value, unknown code, execute while busy
        wr(8'h80, 16'h0041); wr(8'hC0, 16'h0002);
        rd(8'hCC, got); chk("R4 bad execute value", got, 16'h8080);
        wr(8'h80, 16'h0055); wr(8'hC0, 16'h0001);
        rd(8'hCC, got); chk("R4 unknown opcode", got, 16'h8080);
        launch(8'h41, 16'h0000);
        wr(8'hC0, 16'h0001);
        repeat (6) @(negedge clk);
        rd(8'hCC, got); chk("R4 busy execute no restart (busy)", got, 16'h8000);
        rd(8'hCC, got); chk("R4 busy execute no restart (ready)", got, 16'h8080);

        // R5 / R11: lock map
        launch(8'h61, 16'h0002); settle();
        launch(8'h65, 16'h0002); settle();
        rd(8'h84, got); chk("R11 lock status locked", got, 16'h0001);
        launch(8'h41, 16'h0002);
        rd(8'hCC, got); chk("R5 locked program aborts", got, 16'h8082);
        rd(8'hCC, got); chk("R8 flag cleared by read", got, 16'h8080);
        launch(8'h20, 16'h0003);
        rd(8'hCC, got); chk("R5 unlocked block runs", got, 16'h8000);
        settle();
        launch(8'h62, 16'h0002); settle();
        launch(8'h65, 16'h0002); settle();
        rd(8'h84, got); chk("R11 lock status unlocked", got, 16'h0000);
        launch(8'h41, 16'h0002);
        rd(8'hCC, got); chk("R5 program after unlock runs", got, 16'h8000);
        settle();

        // R6 / R7: suspend and resume with remaining count
        launch(8'hE9, 16'h0000);
        repeat (3) @(negedge clk);
        wr(8'hC8, 16'h0001);
        rd(8'hCC, got); chk("R6 program suspended", got, 16'h8084);
        wr(8'h80, 16'h00D0); wr(8'hC0, 16'h0001);
        repeat (4) @(negedge clk);
        rd(8'hCC, got); chk("R7 resume remaining (busy)", got, 16'h8000);
        rd(8'hCC, got); chk("R7 resume remaining (ready)", got, 16'h8080);
        launch(8'h20, 16'h0000);
        wr(8'hC8, 16'h0001);
        rd(8'hCC, got); chk("R6 erase suspended", got, 16'h80C0);
        wr(8'h80, 16'h00D0); wr(8'hC0, 16'h0001);
        rd(8'hCC, got); chk("R7 suspend bit cleared on resume", got, 16'h8000);
        settle();
        rd(8'hCC, got); chk("R7 erase completes", got, 16'h8080);
        launch(8'hD0, 16'h0000);
        rd(8'hCC, got); chk("R7 resume while idle ignored", got, 16'h8080);

        // R9: low voltage
        vpp_low = 1'b1;
        launch(8'h41, 16'h0000);
        rd(8'hCC, got); chk("R9 program aborted on low voltage", got, 16'h8088);
        rd(8'hCC, got); chk("R8 voltage flag cleared", got, 16'h8080);
        launch(8'h98, 16'h0000);
        rd(8'hCC, got); chk("R9 query unaffected by low voltage", got, 16'h8000);
        settle();
        vpp_low = 1'b0;

        // R10: failure at completion
        op_fail = 1'b1;
        launch(8'h41, 16'h0000); settle();
        rd(8'hCC, got); chk("R10 program error flag", got, 16'h8090);
        launch(8'h20, 16'h0000); settle();
        rd(8'hCC, got); chk("R10 erase error flag", got, 16'h80A0);
        op_fail = 1'b0;
        rd(8'hCC, got); chk("R8 both flags cleared", got, 16'h8080);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule